// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block turns a simple synchronous host port into the strobe sequences of an asynchronous x16 EDO DRAM whose address pins are shared between row and column. One host request becomes one random-access cycle. The 20-bit word address is split into a 10-bit row, shown while the row strobe falls, and a 10-bit column, shown while the column strobes fall. Byte enables choose which of the two column strobes fire. The lower-lane strobe `dram_lcas_n` serves data bits 7:0 and the upper-lane strobe `dram_ucas_n` serves bits 15:8.

Writes use early-write timing: write enable goes low before any column strobe falls, so the DRAM never drives the bus during a write. A free-running timer requests a CAS-before-RAS refresh at a fixed interval. A pending refresh wins against new host traffic. Every strobe interval is a nanosecond limit turned into a clock count, rounded up, so the same RTL can be retimed for another clock or speed grade by changing parameters.

Top module: `edo_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, `dram_ras_n`, `dram_ucas_n`, `dram_lcas_n`, `dram_we_n` and `dram_oe_n` are all 1, `dram_dq_oe` is 0, and `req_ready` is 1 unless a refresh is pending.
- R2: For a host cycle, `dram_addr` carries `req_addr[19:10]` when `dram_ras_n` falls and `req_addr[9:0]` when the column strobes fall.
- R3: A read holds `dram_we_n` at 1 and `dram_oe_n` at 0 while the column strobes are low. It returns `rd_data` with a `rd_valid` pulse exactly one cycle long. Data lanes whose byte enable is 0 read as zero.
- R4: `req_be[0]` enables `dram_lcas_n` (bits 7:0) and `req_be[1]` enables `dram_ucas_n` (bits 15:8). A write with one byte enabled leaves the other byte of the word unchanged.
- R5: A write drives `dram_we_n` low at least one clock before the first column strobe falls and keeps `dram_oe_n` at 1 for the whole cycle. `dram_dq_oe` is 1 only while `dram_we_n` is 0.
- R6: A refresh lowers both column strobes while `dram_ras_n` is 1, then lowers `dram_ras_n`. A refresh starts once every ceil(T_REFI_NS/CLK_NS) cycles, and traffic delays it by at most one host cycle.
- R7: While a refresh is pending or in progress, `req_ready` is 0, and a started refresh runs to its end.
- R8: Between two falling edges of `dram_ras_n` there are at least ceil(T_RC_NS/CLK_NS) cycles, with `dram_ras_n` high for at least ceil(T_RP_NS/CLK_NS) of them.
- R9: Read latency from the accepting clock edge to `rd_valid` is RCD + max(CAC, RAC - RCD) + 1 cycles. Each term is its nanosecond limit divided by CLK_NS and rounded up, which gives 4 cycles with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in bits 19:10, column in 9:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_ready | output | 1 | Request accepted at a clock edge where valid and ready are both 1 |
| rd_data | output | 16 | Read data, disabled lanes zero |
| rd_valid | output | 1 | One-cycle read-data strobe |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_oe | output | 1 | Controller drives the data bus |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_in | input | 16 | Data returned from the DRAM |

## Verification
The bound checker watches the cycle-level rules on every clock:
- idle strobe levels;
- write enable leading the column strobes;
- data drive only under write enable;
- output enable never low during a write;
- a one-cycle read pulse;
- refresh holding off the host;
- CAS low before the row strobe falls in a refresh;
- the precharge and row-cycle windows, counted in the checker.

Only the bench's scenarios can show the rest. This covers the row and column values on the pins, lane masking and byte preservation through write-then-read sequences, and exact read latency. It also covers the refresh period measured over a long idle stretch and under traffic.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_CAP, ST_PRE, ST_RCAS, ST_RRAS
  } edo_state_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // precharge length so that low time plus precharge reaches the cycle limit
  function automatic int pre_len(input int low_c, input int rp_c, input int rc_c);
    return (rc_c > low_c) ? max_of(rp_c, rc_c - low_c) : rp_c;
  endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic pend
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0;
      pend <= 1'b0;
    end else begin
      if (tick == LAST) begin
        tick <= '0;
        pend <= 1'b1;
      end else begin
        tick <= tick + 1'b1;
        if (take) pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
  parameter int AW = 20
) (
  input  logic [AW-1:0]   addr,
  input  logic            col_sel,
  output logic [AW/2-1:0] pins
);
  localparam int MW = AW / 2;

  always_comb pins = col_sel ? addr[MW-1:0] : addr[AW-1:MW];
endmodule

// File: rtl/edo_strobe_fsm.sv
module edo_strobe_fsm
  import edo_ctrl_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int RCD_C    = 1,
  parameter int COL_C    = 2,
  parameter int PRE_RD_C = 2,
  parameter int PRE_WR_C = 3,
  parameter int REF_C    = 3,
  parameter int PRE_RF_C = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_req,
  input  logic       host_wr,
  input  logic       ref_pend,
  output edo_state_t state,
  output logic       wr_q
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            state <= ST_RCAS;
            cnt   <= '0;
          end else if (host_req) begin
            state <= ST_ROW;
            cnt   <= CNT_W'(RCD_C - 1);
            wr_q  <= host_wr;
          end
        end
        ST_ROW: begin
          state <= ST_COL;
          cnt   <= CNT_W'(COL_C - 1);
        end
        ST_COL: begin
          if (wr_q) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(PRE_WR_C - 1);
          end else begin
            state <= ST_CAP;
            cnt   <= '0;
          end
        end
        ST_CAP: begin
          state <= ST_PRE;
          cnt   <= CNT_W'(PRE_RD_C - 1);
        end
        ST_RCAS: begin
          state <= ST_RRAS;
          cnt   <= CNT_W'(REF_C - 1);
        end
        ST_RRAS: begin
          state <= ST_PRE;
          cnt   <= CNT_W'(PRE_RF_C - 1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int CLK_NS    = 20,
  parameter int T_RAC_NS  = 60,
  parameter int T_CAC_NS  = 15,
  parameter int T_RC_NS   = 104,
  parameter int T_RCD_NS  = 20,
  parameter int T_RP_NS   = 40,
  parameter int T_REFI_NS = 15600,
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int CNT_W     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [1:0]      req_be,
  output logic            req_ready,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            dram_ras_n,
  output logic            dram_ucas_n,
  output logic            dram_lcas_n,
  output logic            dram_we_n,
  output logic            dram_oe_n,
  output logic [AW/2-1:0] dram_addr,
  output logic            dram_dq_oe,
  output logic [DW-1:0]   dram_dq_out,
  input  logic [DW-1:0]   dram_dq_in
);
  localparam int HB       = DW / 2;
  localparam int RAC_C    = ns_to_cyc(T_RAC_NS, CLK_NS);
  localparam int CAC_C    = ns_to_cyc(T_CAC_NS, CLK_NS);
  localparam int RC_C     = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int RCD_C    = ns_to_cyc(T_RCD_NS, CLK_NS);
  localparam int RP_C     = ns_to_cyc(T_RP_NS, CLK_NS);
  localparam int REFI_C   = ns_to_cyc(T_REFI_NS, CLK_NS);
  localparam int COL_C    = (RAC_C > RCD_C) ? max_of(CAC_C, RAC_C - RCD_C) : CAC_C;
  localparam int PRE_RD_C = pre_len(RCD_C + COL_C + 1, RP_C, RC_C);
  localparam int PRE_WR_C = pre_len(RCD_C + COL_C, RP_C, RC_C);
  localparam int PRE_RF_C = pre_len(RAC_C, RP_C, RC_C);

  edo_state_t      state;
  logic            wr_q;
  logic [AW-1:0]   addr_q;
  logic [1:0]      be_q;
  logic [DW-1:0]   wdata_q;

  // named internal events, also observed by the checker
  logic idle_w, ref_pend_w, accept_w, ref_take_w;
  logic host_ras_w, host_cas_w, ref_cas_w, col_sel_w;

  edo_refresh_timer #(.INTERVAL(REFI_C)) u_timer (
    .clk(clk), .rst_n(rst_n), .take(ref_take_w), .pend(ref_pend_w)
  );

  edo_strobe_fsm #(
    .CNT_W(CNT_W), .RCD_C(RCD_C), .COL_C(COL_C), .PRE_RD_C(PRE_RD_C),
    .PRE_WR_C(PRE_WR_C), .REF_C(RAC_C), .PRE_RF_C(PRE_RF_C)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .host_req(req_valid), .host_wr(req_write),
    .ref_pend(ref_pend_w), .state(state), .wr_q(wr_q)
  );

  edo_addr_mux #(.AW(AW)) u_amux (
    .addr(addr_q), .col_sel(col_sel_w), .pins(dram_addr)
  );

  always_comb begin
    idle_w     = (state == ST_IDLE);
    req_ready  = idle_w && !ref_pend_w;
    accept_w   = req_ready && req_valid;
    ref_take_w = idle_w && ref_pend_w;
    host_cas_w = (state == ST_COL) || (state == ST_CAP);
    host_ras_w = (state == ST_ROW) || host_cas_w;
    ref_cas_w  = (state == ST_RCAS) || (state == ST_RRAS);
    col_sel_w  = host_cas_w;
  end

  always_comb begin
    dram_ras_n  = !(host_ras_w || (state == ST_RRAS));
    dram_lcas_n = !((host_cas_w && be_q[0]) || ref_cas_w);
    dram_ucas_n = !((host_cas_w && be_q[1]) || ref_cas_w);
    dram_we_n   = !(wr_q && ((state == ST_ROW) || (state == ST_COL)));
    dram_oe_n   = !(!wr_q && host_cas_w);
    dram_dq_oe  = !dram_we_n;
    dram_dq_out = wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      be_q     <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (accept_w) begin
        addr_q  <= req_addr;
        be_q    <= req_be;
        wdata_q <= req_wdata;
      end
      rd_valid <= (state == ST_CAP);
      if (state == ST_CAP)
        rd_data <= dram_dq_in & {{HB{be_q[1]}}, {HB{be_q[0]}}};
    end
  end
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
  parameter int RP_C  = 2,
  parameter int RC_C  = 6,
  parameter int CNT_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic idle_w,
  input logic ref_pend_w,
  input logic req_ready,
  input logic rd_valid,
  input logic dram_ras_n,
  input logic dram_ucas_n,
  input logic dram_lcas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);
  logic [CNT_W-1:0] hi_cnt, cyc_cnt;
  logic             ras_prev;
  localparam logic [CNT_W-1:0] SAT = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= SAT;
      cyc_cnt  <= SAT;
      ras_prev <= 1'b1;
    end else begin
      ras_prev <= dram_ras_n;
      if (!dram_ras_n) hi_cnt <= '0;
      else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
      if (!dram_ras_n && ras_prev) cyc_cnt <= 1;
      else if (cyc_cnt != SAT) cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |-> (dram_ras_n && dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n && !dram_dq_oe));

  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_oe_not_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> dram_we_n);

  assert_drive_under_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_we_n && dram_oe_n));

  assert_early_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_we_n) |-> $past(!dram_we_n));

  assert_cbr_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && (!dram_lcas_n || !dram_ucas_n)) |-> $past(!dram_lcas_n && !dram_ucas_n));

  assert_refresh_holds_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend_w && idle_w) |-> !req_ready);

  assert_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= CNT_W'(RP_C)));

  assert_row_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (cyc_cnt >= CNT_W'(RC_C)));
endmodule

bind edo_ctrl edo_ctrl_chk #(.RP_C(RP_C), .RC_C(RC_C), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_w(idle_w), .ref_pend_w(ref_pend_w),
  .req_ready(req_ready), .rd_valid(rd_valid), .dram_ras_n(dram_ras_n),
  .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n),
  .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/edo_ctrl_bench.sv
module edo_ctrl_bench;
  localparam int CLK = 20;

  function automatic int cdiv(input int ns);
    return (ns + CLK - 1) / CLK;
  endfunction

  localparam int RAC_E  = cdiv(60);
  localparam int CAC_E  = cdiv(15);
  localparam int RCD_E  = cdiv(20);
  localparam int RC_E   = cdiv(104);
  localparam int RP_E   = cdiv(40);
  localparam int REFI_E = cdiv(15600);
  localparam int LAT_E  = RCD_E + ((CAC_E > RAC_E - RCD_E) ? CAC_E : RAC_E - RCD_E) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rd_valid, dram_ras_n, dram_ucas_n, dram_lcas_n;
  logic dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] rd_data, dram_dq_out;
  logic [9:0]  dram_addr;
  logic [15:0] dq_drv = '0;

  always #(CLK/2) clk = ~clk;

  edo_ctrl u_edo_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq_oe(dram_dq_oe), .dram_dq_out(dram_dq_out), .dram_dq_in(dq_drv)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- scoreboard ----------------
  logic [15:0] shadow [int];
  logic [15:0] exp_q [$];
  int          acc_q [$];
  logic [19:0] cur_addr = '0;
  logic [1:0]  cur_be = '0;

  function automatic logic [15:0] shadow_rd(input logic [19:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
  endfunction

  task automatic host_op(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] w;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    cur_addr = a; cur_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    w = shadow_rd(a);
    if (wr) begin
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
    end else begin
      exp_q.push_back({be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00});
      acc_q.push_back(cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected rd_valid", 32'(rd_data), 0);
      else begin
        logic [15:0] e;
        int a;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        chk(rd_data == e, "R3 R4 read data", 32'(rd_data), 32'(e));
        chk(cyc - a == LAT_E, "R9 read latency", 32'(cyc - a), 32'(LAT_E));
      end
    end
  end

  // ---------------- DRAM model and pin monitor ----------------
  logic [15:0] mem [int];
  logic p_ras = 1'b1, p_l = 1'b1, p_u = 1'b1, p_we = 1'b1;
  logic [9:0] row_l = '0;
  bit   in_ref = 1'b0, seen_fall = 1'b0, seen_ref = 1'b0;
  int   last_fall = 0, hi_run = 0, last_ref = 0, refs = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(dram_dq_oe && dram_we_n), "R5 bus driven without write enable", 32'(dram_dq_oe), 0);
      if ((in_ref || (dram_ras_n && (!dram_lcas_n || !dram_ucas_n))) && req_ready)
        chk(1'b0, "R7 ready during refresh", 32'(req_ready), 0);
      if (p_ras && !dram_ras_n) begin
        if (seen_fall) begin
          chk(cyc - last_fall >= RC_E, "R8 row cycle", 32'(cyc - last_fall), 32'(RC_E));
          chk(hi_run >= RP_E, "R8 precharge", 32'(hi_run), 32'(RP_E));
        end
        seen_fall = 1'b1;
        last_fall = cyc;
        if (!dram_lcas_n || !dram_ucas_n) begin
          in_ref = 1'b1;
          chk(!p_l && !p_u && p_ras, "R6 CAS before RAS", {p_ras, p_u, p_l}, 3'b100);
          if (seen_ref) begin
            chk(cyc - last_ref <= REFI_E + 10 && cyc - last_ref >= REFI_E - 10,
                "R6 refresh interval", 32'(cyc - last_ref), 32'(REFI_E));
          end else begin
            chk(cyc <= REFI_E + 20, "R6 first refresh", 32'(cyc), 32'(REFI_E));
          end
          seen_ref = 1'b1;
          last_ref = cyc;
          refs++;
        end else begin
          row_l = dram_addr;
          chk(dram_addr == cur_addr[19:10], "R2 row address", 32'(dram_addr), 32'(cur_addr[19:10]));
        end
      end
      if (dram_ras_n) begin
        in_ref = 1'b0;
        hi_run++;
      end else hi_run = 0;
      if (!dram_ras_n && !in_ref && ((p_l && !dram_lcas_n) || (p_u && !dram_ucas_n))) begin
        int key;
        logic [15:0] m;
        key = int'({row_l, dram_addr});
        m = mem.exists(key) ? mem[key] : 16'h0000;
        chk(dram_addr == cur_addr[9:0], "R2 column address", 32'(dram_addr), 32'(cur_addr[9:0]));
        chk({!dram_ucas_n, !dram_lcas_n} == cur_be, "R4 strobe per byte enable",
            32'({!dram_ucas_n, !dram_lcas_n}), 32'(cur_be));
        if (!dram_we_n) begin
          chk(!p_we && dram_dq_oe && dram_oe_n, "R5 early write",
              {p_we, dram_dq_oe, dram_oe_n}, 3'b011);
          if (!dram_lcas_n) m[7:0]  = dram_dq_out[7:0];
          if (!dram_ucas_n) m[15:8] = dram_dq_out[15:8];
          mem[key] = m;
        end else begin
          chk(!dram_oe_n, "R3 output enable on read", 32'(dram_oe_n), 0);
          dq_drv = {!dram_ucas_n ? m[15:8] : 8'hA5, !dram_lcas_n ? m[7:0] : 8'h5A};
        end
      end
      p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n; p_we = dram_we_n;
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 0);
      summary();
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", 32'(req_ready), 1);
    chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n} == 5'h1f,
        "R1 strobes idle", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'h1f);
    chk(!dram_dq_oe && !rd_valid, "R1 bus released", {dram_dq_oe, rd_valid}, 0);

    host_op(1, 20'hABCDE, 16'h1234, 2'b11);
    host_op(0, 20'hABCDE, 16'h0, 2'b11);
    host_op(1, 20'h00401, 16'hCAFE, 2'b11);
    host_op(1, 20'h00401, 16'h77EE, 2'b01);   // R4 low byte only
    host_op(0, 20'h00401, 16'h0, 2'b11);
    host_op(1, 20'h00401, 16'h99AA, 2'b10);   // R4 high byte only
    host_op(0, 20'h00401, 16'h0, 2'b11);
    host_op(0, 20'h00401, 16'h0, 2'b01);      // R3 upper lane masked
    host_op(0, 20'h00401, 16'h0, 2'b10);      // R3 lower lane masked
    host_op(0, 20'hFFFFF, 16'h0, 2'b11);
    host_op(1, 20'hFFFFF, 16'hFFFF, 2'b11);
    host_op(0, 20'hFFFFF, 16'h0, 2'b11);
    host_op(1, 20'h00000, 16'h0001, 2'b11);
    host_op(0, 20'h00000, 16'h0, 2'b11);

    for (int i = 0; i < 300; i++) begin
      logic [19:0] a;
      a = 20'((i * 37) ^ (i << 11));
      host_op(1, a, 16'(i * 16'h0107 + 3), 2'(1 + (i % 3)));
      host_op(0, a, 16'h0, 2'b11);
    end

    repeat (3000) @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    chk(refs >= cyc / REFI_E - 1, "R6 refresh count", 32'(refs), 32'(cyc / REFI_E - 1));
    chk(req_ready && dram_ras_n && !dram_dq_oe, "R1 idle at end", {req_ready, dram_ras_n, dram_dq_oe}, 3'b110);
    done = 1'b1;
    summary();
  end
endmodule